// File: doc/BRIEF.md
# Encoded-Interval Watchdog Timer

This block is a watchdog timer programmed through one byte-wide control register. The two low bits of that register choose a resolution and the next five bits give a multiplier. The timeout is the multiplier times four raised to the resolution, counted in periods of an external 16 Hz tick. A value whose multiplier field is zero disables the watchdog.

Supervisory software keeps the watchdog alive by writing the control register or just reading it. Either access starts the countdown again. A write loads the new value and a read reloads the value already stored. When the countdown runs out, a sticky timeout flag is set. The top bit of the control register then chooses the action:
- If the top bit is set, the block clears the control register, clears one bit of a companion day/century byte and sends a one-cycle system reset request.
- If the top bit is clear, the block sends a one-cycle interrupt pulse and leaves the control register unchanged.

After an expiry the counter stays idle until the next restart. The 16 Hz tick is generated elsewhere.

Top module: `wdt_encoded`

## Requirements
- R1: Register map at `addr_i`: 0 = control, 1 = status, 2 = day/century, 3 = reserved. In the control byte, bits [1:0] are the resolution `r`, bits [6:2] are the multiplier `m` and bit 7 is the steering bit. After a restart, expiry happens on the `m * 4**r`-th tick pulse and on no earlier tick.
- R2: When the multiplier field is zero, including a control value of 0x00, the watchdog never expires and neither output ever pulses.
- R3: A write to address 0 stores `wdata_i`, clears status bit 7 and restarts the countdown with the written value.
- R4: A read of address 0 returns the stored value and restarts the countdown with that stored value.
- R5: Expiry sets status bit 7, which reads back as 0x80 at address 1. All other status bits read zero, and writes to address 1 change nothing.
- R6: If the steering bit is set at expiry, the block clears the control byte to 0x00, clears bit 6 of the day/century byte and drives `rst_req_o` high for exactly one cycle. `irq_o` stays low.
- R7: If the steering bit is clear at expiry, the block drives `irq_o` high for exactly one cycle, keeps the control byte unchanged and leaves `rst_req_o` low.
- R8: After an expiry, further ticks cause no output until the next restart. A restart in the same cycle as the final tick takes priority and no expiry occurs.
- R9: After reset, every register reads 0x00 and both outputs are low. Address 3 always reads 0x00. The day/century byte is fully readable and writable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse at 16 Hz |
| sel_i | input | 1 | Register access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from `addr_i` |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest case to reach from the ports is a restart that arrives in the same clock cycle as the tick that would otherwise end the countdown. The stimulus creates it by raising the tick pulse and a control-register write on the same clock edge, using a one-tick interval, and then confirms that no output pulses. The longest interval (1984 ticks) is also run to completion, so the full counter width and the largest resolution shift are exercised. Keep-alive by read is shown by an interval that survives well past its nominal length because of a mid-count read.

// File: rtl/wdt_enc_pkg.sv
package wdt_enc_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned ADDR_W    = 2;
  localparam int unsigned STEER_BIT = 7;
  localparam int unsigned DAYC_BIT  = 6;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_STAT  = 2'd1,
    ADDR_DAYC  = 2'd2,
    ADDR_RSVD  = 2'd3
  } wdt_addr_e;
endpackage

// File: rtl/wdt_interval_dec.sv
module wdt_interval_dec #(
  parameter int unsigned RES_W  = 2,
  parameter int unsigned MULT_W = 5,
  localparam int unsigned FIELD_W = RES_W + MULT_W,
  localparam int unsigned NRES    = 1 << RES_W,
  localparam int unsigned CNT_W   = MULT_W + 2 * (NRES - 1)
) (
  input  logic [FIELD_W-1:0] field_i,
  output logic [CNT_W-1:0]   ticks_o
);
  logic [MULT_W-1:0] mult;
  logic [RES_W-1:0]  res;
  logic [CNT_W-1:0]  opt [NRES];

  assign mult = field_i[RES_W +: MULT_W];
  assign res  = field_i[RES_W-1:0];

  // one pre-shifted candidate per resolution step (x4 each)
  for (genvar g = 0; g < NRES; g++) begin : g_res
    assign opt[g] = {{(CNT_W-MULT_W){1'b0}}, mult} << (2 * g);
  end

  assign ticks_o = opt[res];
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             tick_i,
  output logic             expire_o,
  output logic             armed_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  assign expire_o = armed_q && tick_i && !restart_i && (cnt_q == CNT_W'(1));
  assign armed_o  = armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q   <= load_i;
      armed_q <= (load_i != '0);
    end else if (armed_q && tick_i) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) armed_q <= 1'b0;
    end
  end

  assert_idle_after_expiry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !armed_q);
  assert_zero_load_disarms_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && load_i == '0) |=> !armed_q);
  assert_armed_nonzero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (cnt_q != '0));
endmodule

// File: rtl/wdt_encoded.sv
module wdt_encoded
  import wdt_enc_pkg::*;
#(
  parameter int unsigned RES_W  = 2,
  parameter int unsigned MULT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_req_o,
  output logic              irq_o
);
  localparam int unsigned FIELD_W = RES_W + MULT_W;
  localparam int unsigned CNT_W   = MULT_W + 2 * ((1 << RES_W) - 1);

  logic [DATA_W-1:0] ctrl_q, dayc_q, load_src;
  logic              flag_q, rst_req_q, irq_q;
  logic              wr_ctrl, rd_ctrl, wr_stat, wr_dayc, restart, expire, armed, steer;
  logic [CNT_W-1:0]  load_ticks;

  assign wr_ctrl  = sel_i &&  we_i && (addr_i == ADDR_CTRL);
  assign rd_ctrl  = sel_i && !we_i && (addr_i == ADDR_CTRL);
  assign wr_stat  = sel_i &&  we_i && (addr_i == ADDR_STAT);
  assign wr_dayc  = sel_i &&  we_i && (addr_i == ADDR_DAYC);
  assign restart  = wr_ctrl || rd_ctrl;
  assign load_src = wr_ctrl ? wdata_i : ctrl_q;
  assign steer    = ctrl_q[STEER_BIT];

  wdt_interval_dec #(.RES_W(RES_W), .MULT_W(MULT_W)) u_dec (
    .field_i (load_src[FIELD_W-1:0]),
    .ticks_o (load_ticks)
  );

  wdt_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .load_i    (load_ticks),
    .tick_i    (tick_i),
    .expire_o  (expire),
    .armed_o   (armed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      dayc_q    <= '0;
      flag_q    <= 1'b0;
      rst_req_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      rst_req_q <= expire && steer;
      irq_q     <= expire && !steer;
      if (wr_ctrl)              ctrl_q <= wdata_i;
      else if (expire && steer) ctrl_q <= '0;
      if (wr_ctrl)     flag_q <= 1'b0;
      else if (expire) flag_q <= 1'b1;
      if (wr_dayc) dayc_q <= wdata_i;
      if (expire && steer) dayc_q[DAYC_BIT] <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = ctrl_q;
      ADDR_STAT: rdata_o = {flag_q, {(DATA_W-1){1'b0}}};
      ADDR_DAYC: rdata_o = dayc_q;
      default:   rdata_o = '0;
    endcase
  end

  assign rst_req_o = rst_req_q;
  assign irq_o     = irq_q;

  assert_outputs_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rst_req_o && irq_o));
  assert_rst_req_one_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  assert_rst_req_clears_regs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (ctrl_q == '0 && !dayc_q[DAYC_BIT]));
  assert_irq_one_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  assert_expiry_sets_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> flag_q);
  assert_stat_write_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && !expire) |=> $stable(flag_q));
  assert_ctrl_write_clears_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> (!flag_q && armed == ($past(wdata_i[FIELD_W-1:RES_W]) != '0)));
endmodule

// File: tb/tb_wdt_encoded.sv
module tb_wdt_encoded;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, sel = 1'b0, we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rst_req, irq;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  wdt_encoded dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sel_i(sel), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .rst_req_o(rst_req), .irq_o(irq)
  );

  // {control value, expected tick count}
  localparam logic [23:0] VEC [7] = '{
    {8'h04, 16'd1}, {8'h05, 16'd4}, {8'h09, 16'd8}, {8'h0A, 16'd32},
    {8'hFC, 16'd31}, {8'h87, 16'd64}, {8'h7F, 16'd1984}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 1'b0;
  endtask

  task automatic tick_once(output logic r, output logic i);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    r = rst_req; i = irq;
  endtask

  task automatic ticks_quiet(input int n, input string req);
    int pulses = 0;
    logic r, i;
    for (int k = 0; k < n; k++) begin
      tick_once(r, i);
      if (r || i) pulses++;
    end
    check(pulses == 0, req, pulses, 0);
  endtask

  task automatic expect_irq(input string req);
    logic r, i;
    tick_once(r, i);
    check(i && !r, req, {r, i}, 2'b01);
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired before the bench completed");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic r, i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    for (int a = 0; a < 4; a++) begin
      bus_read(2'(a), d);
      check(d == 8'h00, "R9 reset readback", d, 0);
    end
    check(!rst_req && !irq, "R9 outputs after reset", {rst_req, irq}, 0);

    // R1/R6/R7 table of intervals
    for (int v = 0; v < 7; v++) begin
      logic [7:0] val;
      int exp_n, got_n;
      bit steer, fired;
      logic fr, fi;
      val = VEC[v][23:16]; exp_n = int'(VEC[v][15:0]); steer = val[7];
      got_n = 0; fired = 1'b0; fr = 1'b0; fi = 1'b0;
      bus_write(2'd2, 8'hFF);
      bus_write(2'd0, val);
      bus_read(2'd1, d);
      check(d == 8'h00, "R3 flag cleared by control write", d, 0);
      for (int k = 1; k <= exp_n + 1 && !fired; k++) begin
        tick_once(r, i);
        if (r || i) begin fired = 1'b1; got_n = k; fr = r; fi = i; end
      end
      check(got_n == exp_n, "R1 ticks to expiry", got_n, exp_n);
      if (steer) check(fr && !fi, "R6 reset request steered", {fr, fi}, 2'b10);
      else       check(fi && !fr, "R7 interrupt steered", {fr, fi}, 2'b01);
      @(negedge clk);
      check(!rst_req && !irq, "R6 R7 single-cycle pulse", {rst_req, irq}, 0);
      bus_read(2'd1, d);
      check(d == 8'h80, "R5 flag set on expiry", d, 8'h80);
      bus_read(2'd2, d);
      check(d == (steer ? 8'hBF : 8'hFF), "R6 day/century bit 6", d, steer ? 8'hBF : 8'hFF);
      bus_read(2'd0, d);
      check(d == (steer ? 8'h00 : val), "R6 R7 control after expiry", d, steer ? 0 : val);
    end

    // R2 zero multiplier disables
    bus_write(2'd0, 8'h00);
    ticks_quiet(40, "R2 value 0x00 never expires");
    bus_write(2'd0, 8'h80);
    ticks_quiet(40, "R2 value 0x80 never expires");
    bus_write(2'd0, 8'h03);
    ticks_quiet(80, "R2 value 0x03 never expires");

    // R4 read restarts with stored value
    bus_write(2'd0, 8'h09);
    ticks_quiet(5, "R4 before keep-alive read");
    bus_read(2'd0, d);
    check(d == 8'h09, "R4 read returns stored value", d, 8'h09);
    ticks_quiet(7, "R4 countdown restarted by read");
    expect_irq("R4 expiry 8 ticks after read");

    // R3 write restarts with new value
    bus_write(2'd0, 8'h09);
    ticks_quiet(5, "R3 before rewrite");
    bus_write(2'd0, 8'h05);
    ticks_quiet(3, "R3 countdown reloaded with new value");
    expect_irq("R3 expiry 4 ticks after rewrite");

    // R8 idle after expiry
    ticks_quiet(20, "R8 idle after expiry");

    // R5 status write ignored
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, d);
    check(d == 8'h80, "R5 status write of 0x00 ignored", d, 8'h80);
    bus_write(2'd0, 8'h00);
    bus_write(2'd1, 8'hFF);
    bus_read(2'd1, d);
    check(d == 8'h00, "R5 status write of 0xFF ignored", d, 0);

    // R8 restart coincides with final tick
    bus_write(2'd0, 8'h04);
    @(negedge clk); tick = 1'b1; sel = 1'b1; we = 1'b1; addr = 2'd0; wdata = 8'h04;
    @(negedge clk); tick = 1'b0; sel = 1'b0; we = 1'b0;
    check(!rst_req && !irq, "R8 restart beats final tick", {rst_req, irq}, 0);
    @(negedge clk);
    check(!rst_req && !irq, "R8 no late expiry", {rst_req, irq}, 0);
    expect_irq("R8 expiry after the reloaded interval");

    // R9 reserved address and day/century storage
    bus_write(2'd3, 8'h5A);
    bus_read(2'd3, d);
    check(d == 8'h00, "R9 reserved reads zero", d, 0);
    bus_write(2'd2, 8'h3C);
    bus_read(2'd2, d);
    check(d == 8'h3C, "R9 day/century storage", d, 8'h3C);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule